// File: doc/BRIEF.md
# Colour Palette Register Port

This block puts a 256-entry red/green/blue colour lookup table behind a byte-wide host register port. The host sees four byte registers. Two of them load the low and high halves of a 16-bit internal address. The third is a colour-map port. The fourth is a general data port that reaches the internal control registers addressed by that 16-bit value.

Colour entries travel through the colour-map port as three bytes in sequence: red, then green, then blue. The first two bytes wait in staging registers. The entry is replaced in one step when the blue byte arrives. After that the entry index moves on by one, so a whole palette can be streamed after a single address load. Reads of the colour-map port walk the same sequence.

The display side presents an 8-bit pixel index every cycle. It receives the 24-bit colour one cycle later, whatever the host is doing. One control register, the cursor command at internal address 0x0300, drives a cursor enable output.

Top module: `palette_port`

## Requirements
- R1: Register select encoding is 2'd0 address low byte, 2'd1 address high byte, 2'd2 colour-map port, 2'd3 data port. A write to select 0 or 1 loads that half of the 16-bit internal address. A read returns its value on host_rdata at the clock edge after the read is presented.
- R2: The first and second colour-map writes of a triplet (phase red, phase green) are only staged. The table and the internal address are not changed by them.
- R3: The third colour-map write (phase blue) stores {red, green, blue} into the entry given by the address low byte, with red in bits 23:16, green in 15:8 and blue in 7:0. The low byte then increments, wrapping from 0xFF to 0x00 with the high byte unchanged, and the phase returns to red.
- R4: A write to either address register returns the phase to red, and a partly written triplet is discarded.
- R5: A colour-map read returns the red, green and blue byte of the entry at the address low byte, one per read in that order. It shares the phase with writes, and the address increments after the blue byte.
- R6: The cursor command register sits at internal address 0x0300 and resets to 0xC0. Data port writes and reads at that address reach it. cursor_en is high exactly when the register is nonzero, so writing 0x00 disables the cursor.
- R7: Data port writes to any other internal address have no effect, and data port reads there return 0x00.
- R8: pix_color shows the entry for the pix_index sampled at the previous clock edge. If a host commit to the same entry falls in that cycle, the old colour is shown, and the new one appears at the next lookup.
- R9: During reset the internal address is 0x0000, the phase is red, the cursor command is 0xC0, and host_rdata and pix_color are zero.
- R10: When host_wr and host_rd are high together, only the write acts. host_rdata keeps its value whenever no read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| pix_index | input | 8 | Pixel colour index |
| pix_color | output | 24 | Looked-up colour {red, green, blue} |
| cursor_en | output | 1 | Cursor enable |

## Verification
The collision that matters is a host blue-byte commit landing in the same cycle as a pixel lookup of that same entry. The bench provokes it by steering pix_index onto the entry being committed exactly while the blue byte is written, and also on the cycle after. Its reference model reads the old table contents before applying the host write in each clock. A lookup in the commit cycle is therefore judged against the previous colour, and the lookup in the next cycle against the new one. A second overlap, a read and a write strobe in one cycle, is judged by checking that the read data holds while the write lands.

// File: rtl/palette_port.sv
module palette_port #(
  parameter int ENTRIES     = 256,
  parameter int CW          = 8,
  parameter logic [15:0] CURSOR_ADDR = 16'h0300,
  parameter logic [7:0]  CURSOR_RST  = 8'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [$clog2(ENTRIES)-1:0] pix_index,
  output logic [3*CW-1:0]   pix_color,
  output logic              cursor_en
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [1:0] PH_R = 2'd0, PH_G = 2'd1, PH_B = 2'd2;

  logic [3*CW-1:0] tab [ENTRIES];
  logic [15:0]     addr;
  logic [1:0]      phase;
  logic [CW-1:0]   red_s, green_s;
  logic [7:0]      cursor_cmd;
  logic [7:0]      rd_mux;
  logic [3*CW-1:0] cur_entry;

  wire [IW-1:0] idx    = addr[IW-1:0];
  wire do_rd           = host_rd && !host_wr;
  wire cm_wr           = host_wr && host_sel == 2'd2;
  wire cm_rd           = do_rd && host_sel == 2'd2;
  wire cm_step         = cm_wr || cm_rd;
  wire commit          = cm_wr && phase == PH_B;
  wire dp_wr           = host_wr && host_sel == 2'd3;
  wire addr_wr         = host_wr && host_sel[1] == 1'b0;

  assign cur_entry = tab[idx];
  assign cursor_en = |cursor_cmd;

  always_comb begin
    case (host_sel)
      2'd0: rd_mux = addr[7:0];
      2'd1: rd_mux = addr[15:8];
      2'd2: rd_mux = (phase == PH_R) ? cur_entry[3*CW-1:2*CW] :
                     (phase == PH_G) ? cur_entry[2*CW-1:CW] : cur_entry[CW-1:0];
      default: rd_mux = (addr == CURSOR_ADDR) ? cursor_cmd : 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (commit) tab[idx] <= {red_s, green_s, host_wdata[CW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr       <= '0;
      phase      <= PH_R;
      red_s      <= '0;
      green_s    <= '0;
      cursor_cmd <= CURSOR_RST;
      host_rdata <= '0;
      pix_color  <= '0;
    end else begin
      pix_color <= tab[pix_index];
      if (host_wr && host_sel == 2'd0) begin
        addr[7:0] <= host_wdata;
        phase     <= PH_R;
      end else if (host_wr && host_sel == 2'd1) begin
        addr[15:8] <= host_wdata;
        phase      <= PH_R;
      end else if (cm_step) begin
        if (phase == PH_B) begin
          phase        <= PH_R;
          addr[IW-1:0] <= idx + 1'b1;
        end else begin
          phase <= phase + 2'd1;
        end
      end
      if (cm_wr && phase == PH_R) red_s   <= host_wdata[CW-1:0];
      if (cm_wr && phase == PH_G) green_s <= host_wdata[CW-1:0];
      if (dp_wr && addr == CURSOR_ADDR) cursor_cmd <= host_wdata;
      if (do_rd) host_rdata <= rd_mux;
    end
  end

  AST_ADDR_WR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> phase == PH_R); // R4
  AST_STAGE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_wr && phase != PH_B) |=> $stable(addr)); // R2
  AST_COMMIT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (addr[IW-1:0] == IW'($past(addr[IW-1:0]) + 1) && phase == PH_R)); // R3
  AST_CURSOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_wr && addr == CURSOR_ADDR && host_wdata == 8'h00) |=> !cursor_en); // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> $stable(host_rdata)); // R10
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3); // R5
endmodule

// File: tb/tb_palette_port.sv
module tb_palette_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] host_sel = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, pix_index = 0;
  logic [7:0] host_rdata;
  logic [23:0] pix_color;
  logic cursor_en;

  palette_port dut (.clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_index(pix_index), .pix_color(pix_color), .cursor_en(cursor_en));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit armed = 0, pix_ok = 0, done = 0;
  string cur_tag = "R9";

  int m_addr, m_phase, m_red, m_green, m_cursor, m_rdata, m_pix;
  int m_tab [256];

  always @(posedge clk) begin
    armed <= 1;
    if (!rst_n) begin
      m_addr = 0; m_phase = 0; m_cursor = 8'hC0; m_rdata = 0; m_pix = 0;
    end else begin
      m_pix = m_tab[pix_index];
      if (host_wr) begin
        case (host_sel)
          2'd0: begin m_addr = (m_addr & 16'hFF00) | host_wdata; m_phase = 0; end
          2'd1: begin m_addr = (m_addr & 16'h00FF) | (host_wdata << 8); m_phase = 0; end
          2'd2: begin
            if (m_phase == 0) begin m_red = host_wdata; m_phase = 1; end
            else if (m_phase == 1) begin m_green = host_wdata; m_phase = 2; end
            else begin
              m_tab[m_addr & 255] = (m_red << 16) | (m_green << 8) | host_wdata;
              m_addr = (m_addr & 16'hFF00) | ((m_addr + 1) & 255);
              m_phase = 0;
            end
          end
          default: if (m_addr == 16'h0300) m_cursor = host_wdata;
        endcase
      end else if (host_rd) begin
        case (host_sel)
          2'd0: m_rdata = m_addr & 255;
          2'd1: m_rdata = (m_addr >> 8) & 255;
          2'd2: begin
            m_rdata = (m_tab[m_addr & 255] >> (8 * (2 - m_phase))) & 255;
            if (m_phase == 2) begin
              m_phase = 0;
              m_addr = (m_addr & 16'hFF00) | ((m_addr + 1) & 255);
            end else m_phase = m_phase + 1;
          end
          default: m_rdata = (m_addr == 16'h0300) ? m_cursor : 0;
        endcase
      end
    end
  end

  always @(negedge clk) if (armed && !done) begin
    checks++;
    if (host_rdata !== 8'(m_rdata)) begin
      errors++;
      $display("FAIL %s host_rdata actual=%h expected=%h", cur_tag, host_rdata, 8'(m_rdata));
    end
    checks++;
    if (cursor_en !== (m_cursor != 0)) begin
      errors++;
      $display("FAIL R6 cursor_en actual=%b expected=%b", cursor_en, m_cursor != 0);
    end
    if (!rst_n || pix_ok) begin
      checks++;
      if (pix_color !== 24'(m_pix)) begin
        errors++;
        $display("FAIL %s pix_color actual=%h expected=%h", rst_n ? "R8" : "R9",
                 pix_color, 24'(m_pix));
      end
    end
  end

  task automatic op(input logic [1:0] s, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    host_sel = s; host_wr = w; host_rd = r; host_wdata = d;
    pix_index = pix_index + 8'd37;
  endtask

  task automatic idle();
    @(negedge clk);
    host_wr = 0; host_rd = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    cur_tag = "R3";
    op(0, 1, 0, 8'h00); op(1, 1, 0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      op(2, 1, 0, 8'(i)); op(2, 1, 0, 8'(i ^ 8'h5A)); op(2, 1, 0, 8'(255 - i));
    end
    idle(); idle();
    pix_ok = 1;
    repeat (20) idle();

    cur_tag = "R1";
    op(0, 1, 0, 8'h34); op(1, 1, 0, 8'h12); op(0, 0, 1, 0); op(1, 0, 1, 0); idle();

    cur_tag = "R5";
    op(1, 1, 0, 8'h00); op(0, 1, 0, 8'h10);
    for (int i = 0; i < 6; i++) op(2, 0, 1, 0);
    op(0, 0, 1, 0); idle();

    cur_tag = "R3";
    op(0, 1, 0, 8'hFF); op(2, 1, 0, 8'hA1); op(2, 1, 0, 8'hB2); op(2, 1, 0, 8'hC3);
    op(0, 0, 1, 0); op(1, 0, 1, 0);
    op(0, 1, 0, 8'hFF); op(2, 0, 1, 0); op(2, 0, 1, 0); op(2, 0, 1, 0); idle();

    cur_tag = "R2";
    op(0, 1, 0, 8'h40); op(2, 1, 0, 8'h11); op(2, 1, 0, 8'h22);
    op(0, 0, 1, 0); op(2, 0, 1, 0);
    op(0, 1, 0, 8'h40); op(2, 0, 1, 0); op(2, 0, 1, 0); op(2, 0, 1, 0); idle();

    cur_tag = "R4";
    op(0, 1, 0, 8'h05); op(2, 1, 0, 8'hEE); op(2, 1, 0, 8'hDD);
    op(0, 1, 0, 8'h05); op(2, 1, 0, 8'h01); op(2, 1, 0, 8'h02); op(2, 1, 0, 8'h03);
    op(0, 1, 0, 8'h05); op(2, 0, 1, 0); op(2, 0, 1, 0); op(2, 0, 1, 0); idle();

    cur_tag = "R8";
    op(0, 1, 0, 8'h77); op(2, 1, 0, 8'h9A); op(2, 1, 0, 8'hBC);
    @(negedge clk); host_sel = 2; host_wr = 1; host_rd = 0; host_wdata = 8'hDE; pix_index = 8'h77;
    @(negedge clk); host_wr = 0; pix_index = 8'h77;
    @(negedge clk); pix_index = 8'h78;
    idle();

    cur_tag = "R6";
    op(1, 1, 0, 8'h03); op(0, 1, 0, 8'h00); op(3, 0, 1, 0);
    op(3, 1, 0, 8'h00); op(3, 0, 1, 0); idle();
    op(3, 1, 0, 8'h41); op(3, 0, 1, 0); idle();

    cur_tag = "R7";
    op(1, 1, 0, 8'h01); op(0, 1, 0, 8'h23); op(3, 1, 0, 8'h77); op(3, 0, 1, 0);
    op(1, 1, 0, 8'h03); op(0, 1, 0, 8'h00); op(3, 0, 1, 0); idle();

    cur_tag = "R10";
    op(0, 1, 0, 8'h66); op(0, 0, 1, 0); op(1, 1, 1, 8'h02); idle(); idle();
    op(1, 0, 1, 0); op(0, 1, 1, 8'h99); op(0, 0, 1, 0); idle(); idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule